// File: doc/BRIEF.md
# Double-Buffered Audio Transmit DMA

This block moves audio samples from memory into a transmit FIFO. Software fills two buffer descriptors, called A and B; each holds a start address, a word count and an arm bit. The engine works through the armed buffer one 32-bit word at a time. When that buffer runs out, the engine turns to the other descriptor. Software refills the buffer that has just finished while the engine plays the other one, so the stream continues without a gap.

Words are fetched at a fixed sample rate. The block has no fast clock of its own, so it models that rate with a phase accumulator on its own clock. The accumulator adds 39 every cycle and produces a tick each time it passes a period of (divider + 1) × 128. A tick starts one memory read. The returned word goes into the FIFO.

The block has four sticky interrupt lines: A done, B done, FIFO service and underrun. Software clears each line by writing 1 to its bit. Dropping the enable input stops the engine and clears every interrupt line.

Top module: `pingpong_tx_dma`

## Requirements
- R1: After a synchronous reset, `mem_req`, `fifo_push` and all four `irq` bits are 0.
- R2: While enabled and idle, if the arm bit of the selected buffer is set, the engine loads that buffer's address and count, restarts the pacing accumulator from zero and begins fetching at that address. After reset and after every disable, the selected buffer is A (`desc_sel`=0). B is selected with `desc_sel`=1.
- R3: Each fetch holds `mem_req` high with `mem_addr` stable until `mem_ack`. The acknowledged word (`mem_rdata`) appears on `fifo_wdata` with `fifo_push` high in the following cycle. The address then advances by 4 and the count decreases by 1.
- R4: The number of fetch ticks in the first t running cycles is floor(39·t / (128·(`pace_div`+1))). Any ten successive fetches therefore span 1280·(`pace_div`+1)/39 cycles, with less than one cycle of error.
- R5: When the current count reaches zero, the done bit of that buffer is set (`irq[0]` for A, `irq[1]` for B). The selected buffer toggles, and the current address and count are loaded from the other descriptor.
- R6: After a toggle, fetching continues only if the newly selected buffer is armed. Otherwise the engine halts and stays halted, ignoring the arm bit of the other buffer, until the selected buffer is armed.
- R7: The arm bit of a buffer is cleared by hardware when that buffer completes. A finished buffer is therefore not played again unless software re-arms it.
- R8: A buffer armed with a count of zero completes without any memory read and sets its done bit.
- R9: A consumer pop (`fifo_pop`) while `fifo_empty` is high sets `irq[3]` (underrun). A pop while the FIFO is not empty does not set it.
- R10: `fifo_low` high while enabled sets `irq[2]` (FIFO service request).
- R11: Each `irq` bit stays set until software writes 1 to the same bit of `irq_clr`. A set condition in the same cycle takes priority over the clear. Clearing one bit leaves the others unchanged.
- R12: While `dma_en` is low, no fetch is issued, all `irq` bits read 0 from the next cycle on, and the pacing accumulator is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Transmit DMA enable |
| pace_div | input | DIV_W | Pacing divider field |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | 1 | Descriptor written: 0 = A, 1 = B |
| desc_addr | input | ADDR_W | Start address to write |
| desc_cnt | input | CNT_W | Word count to write |
| desc_go | input | 1 | Arm bit to write |
| irq_clr | input | 4 | Write-1-to-clear for the irq bits |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | DATA_W | Memory read data |
| fifo_push | output | 1 | FIFO push strobe |
| fifo_wdata | output | DATA_W | FIFO push data |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_pop | input | 1 | Consumer pop request |
| fifo_low | input | 1 | FIFO below its refill level |
| irq | output | 4 | [0] A done, [1] B done, [2] FIFO service, [3] underrun |

## Verification
The assertions assume that `mem_ack` is high only in a cycle where `mem_req` is high. They also assume that each fetch is acknowledged before the next pacing tick, so a fetch never has more than one tick waiting behind it. The stimulus keeps to this with a responder that acknowledges every request one cycle after it appears. That round trip is shorter than the shortest pacing period of about 3.3 cycles. `pace_div` and the descriptors of a running buffer are changed only while the engine is disabled or halted, so a spacing measurement always belongs to a single divider setting.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;

    // pacing: 39x source clock divided by (div+1)*128
    localparam int unsigned PLL_MULT   = 39;
    localparam int unsigned PACE_SHIFT = 7;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned NBUF       = 2;
    localparam int unsigned NIRQ       = 4;

    // interrupt bit positions
    localparam int unsigned IRQ_DONE_A = 0;
    localparam int unsigned IRQ_DONE_B = 1;
    localparam int unsigned IRQ_SVC    = 2;
    localparam int unsigned IRQ_URUN   = 3;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RUN  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;

    function automatic buf_sel_e other_buf(input buf_sel_e b);
        return (b == BUF_A) ? BUF_B : BUF_A;
    endfunction

    function automatic int unsigned pace_acc_width(input int unsigned div_w);
        return div_w + PACE_SHIFT + 1;
    endfunction

endpackage

// File: rtl/tx_pace_gen.sv
module tx_pace_gen
    import tx_dma_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned ACC_W = pace_acc_width(DIV_W);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] period;
    logic [ACC_W-1:0] sum;

    always_comb begin
        period = (ACC_W'(div) + ACC_W'(1)) << PACE_SHIFT;
        sum    = acc_q + ACC_W'(PLL_MULT);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (sum >= period) begin
            acc_q <= sum - period;
            tick  <= 1'b1;
        end else begin
            acc_q <= sum;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_desc_bank.sv
module tx_desc_bank
    import tx_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic                        sel,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [CNT_W-1:0]            wcnt,
    input  logic                        wgo,
    input  logic [NBUF-1:0]             go_clr,
    output logic [NBUF-1:0][ADDR_W-1:0] addr_o,
    output logic [NBUF-1:0][CNT_W-1:0]  cnt_o,
    output logic [NBUF-1:0]             go_o
);

    for (genvar g = 0; g < NBUF; g++) begin : g_desc
        logic [ADDR_W-1:0] a_q;
        logic [CNT_W-1:0]  c_q;
        logic              go_q;
        logic              hit;

        assign hit = we && (sel == 1'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q  <= '0;
                c_q  <= '0;
                go_q <= 1'b0;
            end else if (hit) begin
                // a software write wins over the hardware clear
                a_q  <= waddr;
                c_q  <= wcnt;
                go_q <= wgo;
            end else if (go_clr[g]) begin
                go_q <= 1'b0;
            end
        end

        assign addr_o[g] = a_q;
        assign cnt_o[g]  = c_q;
        assign go_o[g]   = go_q;
    end

endmodule

// File: rtl/tx_irq_ctl.sv
module tx_irq_ctl
    import tx_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [NIRQ-1:0] set,
    input  logic [NIRQ-1:0] clr,
    output logic [NIRQ-1:0] irq
);

    for (genvar g = 0; g < NIRQ; g++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst || !en) begin
                q <= 1'b0;
            end else if (set[g]) begin
                q <= 1'b1;
            end else if (clr[g]) begin
                q <= 1'b0;
            end
        end
        assign irq[g] = q;
    end

endmodule

// File: rtl/pingpong_tx_dma.sv
module pingpong_tx_dma
    import tx_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic [DIV_W-1:0]  pace_div,
    input  logic              desc_we,
    input  logic              desc_sel,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [CNT_W-1:0]  desc_cnt,
    input  logic              desc_go,
    input  logic [3:0]        irq_clr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              fifo_empty,
    input  logic              fifo_pop,
    input  logic              fifo_low,
    output logic [3:0]        irq
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

    fetch_state_e      state_q;
    buf_sel_e          buf_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  cur_cnt_q;
    logic              pend_q;
    logic              push_q;
    logic [DATA_W-1:0] wdata_q;

    logic [NBUF-1:0][ADDR_W-1:0] d_addr;
    logic [NBUF-1:0][CNT_W-1:0]  d_cnt;
    logic [NBUF-1:0]             d_go;
    logic [NBUF-1:0]             go_clr;
    logic [NIRQ-1:0]             irq_set;

    logic     tick;
    logic     cur_done;
    logic     start_idle;
    logic     pace_run;
    buf_sel_e nxt_b;

    // ---------------------------------------------------------------
    // control decode
    // ---------------------------------------------------------------
    always_comb begin
        nxt_b      = other_buf(buf_q);
        cur_done   = (state_q == FS_RUN) && (cur_cnt_q == '0);
        start_idle = dma_en && (state_q == FS_IDLE) && d_go[buf_q];
        pace_run   = dma_en && (state_q != FS_IDLE);

        go_clr = '0;
        if (dma_en && cur_done) begin
            go_clr[buf_q] = 1'b1;
        end

        irq_set                = '0;
        irq_set[IRQ_DONE_A]    = cur_done && (buf_q == BUF_A);
        irq_set[IRQ_DONE_B]    = cur_done && (buf_q == BUF_B);
        irq_set[IRQ_SVC]       = fifo_low;
        irq_set[IRQ_URUN]      = fifo_pop && fifo_empty;
    end

    // ---------------------------------------------------------------
    // sub-blocks
    // ---------------------------------------------------------------
    tx_pace_gen #(.DIV_W(DIV_W)) u_pace (
        .clk     (clk),
        .rst     (rst),
        .run     (pace_run),
        .restart (start_idle),
        .div     (pace_div),
        .tick    (tick)
    );

    tx_desc_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
        .clk    (clk),
        .rst    (rst),
        .we     (desc_we),
        .sel    (desc_sel),
        .waddr  (desc_addr),
        .wcnt   (desc_cnt),
        .wgo    (desc_go),
        .go_clr (go_clr),
        .addr_o (d_addr),
        .cnt_o  (d_cnt),
        .go_o   (d_go)
    );

    tx_irq_ctl u_irq (
        .clk (clk),
        .rst (rst),
        .en  (dma_en),
        .set (irq_set),
        .clr (irq_clr),
        .irq (irq)
    );

    // ---------------------------------------------------------------
    // fetch engine
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FS_IDLE;
            buf_q      <= BUF_A;
            cur_addr_q <= '0;
            cur_cnt_q  <= '0;
            pend_q     <= 1'b0;
            push_q     <= 1'b0;
            wdata_q    <= '0;
        end else if (!dma_en) begin
            state_q <= FS_IDLE;
            buf_q   <= BUF_A;
            pend_q  <= 1'b0;
            push_q  <= 1'b0;
        end else begin
            push_q <= 1'b0;
            unique case (state_q)
                FS_IDLE: begin
                    if (d_go[buf_q]) begin
                        cur_addr_q <= d_addr[buf_q];
                        cur_cnt_q  <= d_cnt[buf_q];
                        pend_q     <= 1'b0;
                        state_q    <= FS_RUN;
                    end
                end
                FS_RUN: begin
                    if (cur_cnt_q == '0) begin
                        buf_q      <= nxt_b;
                        cur_addr_q <= d_addr[nxt_b];
                        cur_cnt_q  <= d_cnt[nxt_b];
                        pend_q     <= 1'b0;
                        state_q    <= d_go[nxt_b] ? FS_RUN : FS_IDLE;
                    end else if (pend_q || tick) begin
                        pend_q  <= 1'b0;
                        state_q <= FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (tick) begin
                        pend_q <= 1'b1;
                    end
                    if (mem_ack) begin
                        push_q     <= 1'b1;
                        wdata_q    <= mem_rdata;
                        cur_addr_q <= cur_addr_q + ADDR_STEP;
                        cur_cnt_q  <= cur_cnt_q - CNT_W'(1);
                        state_q    <= FS_RUN;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign mem_req    = (state_q == FS_WAIT);
    assign mem_addr   = cur_addr_q;
    assign fifo_push  = push_q;
    assign fifo_wdata = wdata_q;

endmodule

// File: rtl/pingpong_tx_dma_chk.sv
module pingpong_tx_dma_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_en,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              fifo_push,
    input logic              fifo_pop,
    input logic              fifo_empty,
    input logic              fifo_low,
    input logic [3:0]        irq_clr,
    input logic [3:0]        irq
);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        dma_en && mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_push_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> $past(mem_req && mem_ack));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        dma_en && mem_req && mem_ack |=> mem_addr == $past(mem_addr) + ADDR_W'(4));

    assert_one_per_ack_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req);

    assert_irq_off_R12: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> irq == 4'b0000);

    assert_no_req_off_R12: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> !mem_req);

    assert_underrun_R9: assert property (@(posedge clk) disable iff (rst)
        dma_en && fifo_pop && fifo_empty |=> irq[3]);

    assert_service_R10: assert property (@(posedge clk) disable iff (rst)
        dma_en && fifo_low |=> irq[2]);

    for (genvar k = 0; k < 4; k++) begin : g_sticky
        assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            dma_en && irq[k] && !irq_clr[k] |=> irq[k]);
    end

endmodule

bind pingpong_tx_dma pingpong_tx_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dma_en     (dma_en),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .fifo_low   (fifo_low),
    .irq_clr    (irq_clr),
    .irq        (irq)
);

// File: tb/test_pingpong_tx_dma.sv
`timescale 1ns/1ps
module test_pingpong_tx_dma;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned DIV_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dma_en = 1'b0;
    logic [DIV_W-1:0]  pace_div = '0;
    logic              desc_we = 1'b0;
    logic              desc_sel = 1'b0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [CNT_W-1:0]  desc_cnt = '0;
    logic              desc_go = 1'b0;
    logic [3:0]        irq_clr = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              fifo_push;
    logic [DATA_W-1:0] fifo_wdata;
    logic              fifo_empty = 1'b0;
    logic              fifo_pop = 1'b0;
    logic              fifo_low = 1'b0;
    logic [3:0]        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int push_n = 0;
    int push_cyc [0:255];
    logic [DATA_W-1:0] push_dat [0:255];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pingpong_tx_dma #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
    ) i_pingpong_tx_dma (
        .clk(clk), .rst(rst), .dma_en(dma_en), .pace_div(pace_div),
        .desc_we(desc_we), .desc_sel(desc_sel), .desc_addr(desc_addr),
        .desc_cnt(desc_cnt), .desc_go(desc_go), .irq_clr(irq_clr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .fifo_low(fifo_low),
        .irq(irq)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder: acknowledge one cycle after a request appears
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_word(mem_addr);
        end
    end

    // FIFO side monitor
    always @(negedge clk) begin
        if (fifo_push && push_n < 256) begin
            push_dat[push_n] = fifo_wdata;
            push_cyc[push_n] = cyc;
            push_n = push_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_desc(input logic sel, input logic [ADDR_W-1:0] a,
                           input logic [CNT_W-1:0] c, input logic go);
        @(negedge clk);
        desc_we = 1'b1; desc_sel = sel; desc_addr = a; desc_cnt = c; desc_go = go;
        @(negedge clk);
        desc_we = 1'b0; desc_go = 1'b0;
    endtask

    task automatic wait_push(input int target);
        int t = 0;
        while (push_n < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic clr_irq(input logic [3:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        int delta;
        int err;
        int exp_n;
        logic [ADDR_W-1:0] a;

        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        chk(fifo_push == 1'b0, "R1 fifo_push", 32'(fifo_push), 0);
        chk(irq == 4'b0, "R1 irq", 32'(irq), 0);
        rst = 1'b0;
        dma_en = 1'b1;
        tick_n(2);

        // R2 R3 R5: A then B, both armed
        wr_desc(1'b0, 32'h1000, 16'd5, 1'b1);
        wr_desc(1'b1, 32'h2000, 16'd3, 1'b1);
        wait_push(8);
        chk(push_n == 8, "R5 word count A+B", 32'(push_n), 8);
        for (int i = 0; i < 8; i++) begin
            a = (i < 5) ? 32'h1000 + 32'(4 * i) : 32'h2000 + 32'(4 * (i - 5));
            chk(push_dat[i] == mem_word(a), "R3 word order", push_dat[i], mem_word(a));
        end
        tick_n(4);
        chk(irq[1:0] == 2'b11, "R5 done A and B", 32'(irq), 32'h3);
        tick_n(100);
        // R7: A was disarmed on completion, so nothing more runs
        chk(push_n == 8, "R7 no replay of finished buffer", 32'(push_n), 8);
        clr_irq(4'b0011);
        chk(irq == 4'b0, "R11 clear done bits", 32'(irq), 0);

        // R6: selected buffer is A now; arming B alone must not start it
        wr_desc(1'b1, 32'h3000, 16'd2, 1'b1);
        tick_n(50);
        chk(push_n == 8, "R6 halt ignores other buffer", 32'(push_n), 8);
        wr_desc(1'b0, 32'h4000, 16'd2, 1'b1);
        wait_push(12);
        chk(push_n == 12, "R6 resume count", 32'(push_n), 12);
        chk(push_dat[8]  == mem_word(32'h4000), "R6 resume A first", push_dat[8], mem_word(32'h4000));
        chk(push_dat[10] == mem_word(32'h3000), "R6 continue into B", push_dat[10], mem_word(32'h3000));
        chk(push_dat[11] == mem_word(32'h3004), "R6 continue into B", push_dat[11], mem_word(32'h3004));
        tick_n(20);
        clr_irq(4'b0011);

        // R8: zero-length buffer
        wr_desc(1'b0, 32'h6000, 16'd0, 1'b1);
        tick_n(20);
        chk(irq == 4'b0001, "R8 zero count done A", 32'(irq), 1);
        chk(push_n == 12, "R8 no read for zero count", 32'(push_n), 12);

        // R10 / R11
        @(negedge clk); fifo_low = 1'b1;
        @(negedge clk); fifo_low = 1'b0;
        chk(irq == 4'b0101, "R10 service request", 32'(irq), 32'h5);
        clr_irq(4'b0001);
        chk(irq == 4'b0100, "R11 clear one bit only", 32'(irq), 32'h4);
        @(negedge clk); fifo_low = 1'b1; irq_clr = 4'b0100;
        @(negedge clk); fifo_low = 1'b0; irq_clr = 4'b0000;
        chk(irq == 4'b0100, "R11 set beats clear", 32'(irq), 32'h4);

        // R9 underrun
        @(negedge clk); fifo_pop = 1'b1; fifo_empty = 1'b0;
        @(negedge clk); fifo_pop = 1'b0;
        chk(irq[3] == 1'b0, "R9 pop with data", 32'(irq[3]), 0);
        @(negedge clk); fifo_pop = 1'b1; fifo_empty = 1'b1;
        @(negedge clk); fifo_pop = 1'b0; fifo_empty = 1'b0;
        chk(irq[3] == 1'b1, "R9 pop while empty", 32'(irq[3]), 1);

        // R12 disable: irqs drop, no fetch, selected buffer back to A
        @(negedge clk); dma_en = 1'b0;
        @(negedge clk);
        chk(irq == 4'b0, "R12 irq cleared", 32'(irq), 0);
        wr_desc(1'b0, 32'h5000, 16'd1, 1'b1);
        tick_n(30);
        chk(push_n == 12, "R12 no fetch while off", 32'(push_n), 12);
        @(negedge clk); dma_en = 1'b1;
        wait_push(13);
        chk(push_dat[12] == mem_word(32'h5000), "R12 restart from A", push_dat[12], mem_word(32'h5000));
        tick_n(10);

        // R4 pacing sweep
        for (int d = 0; d < 8; d++) begin
            @(negedge clk); dma_en = 1'b0; pace_div = DIV_W'(d);
            @(negedge clk); dma_en = 1'b1;
            base = push_n;
            wr_desc(1'b0, 32'h8000 + 32'(d * 32'h100), 16'd14, 1'b1);
            wait_push(base + 14);
            chk(push_n == base + 14, "R4 sweep word count", 32'(push_n), 32'(base + 14));
            delta = push_cyc[base + 11] - push_cyc[base + 1];
            err = 39 * delta - 1280 * (d + 1);
            chk(err > -39 && err < 39, "R4 ten-word span", 32'(delta), 32'((1280 * (d + 1)) / 39));
            chk(push_dat[base + 13] == mem_word(32'h8000 + 32'(d * 32'h100) + 52),
                "R3 last word of sweep", push_dat[base + 13],
                mem_word(32'h8000 + 32'(d * 32'h100) + 52));
            tick_n(5);
        end

        // R12 disable mid-buffer
        @(negedge clk); dma_en = 1'b0; pace_div = 4'd3;
        @(negedge clk); dma_en = 1'b1;
        base = push_n;
        wr_desc(1'b0, 32'h9000, 16'd14, 1'b1);
        wait_push(base + 5);
        @(negedge clk); dma_en = 1'b0;
        tick_n(2);
        exp_n = push_n;
        tick_n(100);
        chk(push_n == exp_n, "R12 stop mid-buffer", 32'(push_n), 32'(exp_n));
        chk(mem_req == 1'b0, "R12 request dropped", 32'(mem_req), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule